// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block sits in front of the two ALU inputs of a five-stage in-order pipeline. For the instruction now in the Compute stage, it compares each source register number with the destination numbers of the two older instructions still in flight. It then steers each operand to one of three values:

- the register-file value latched at the end of Decode;
- the result held in the Compute/Memory buffer (RZ);
- the value held in the Memory/Write Back buffer (RY), which also carries load data.

The selects and the muxed operands are produced in the same cycle as the inputs, with no register on the path.

A result can be bypassed only once it exists. A load in the Memory stage has no data in RZ yet. If the next instruction reads that load's destination, the block raises a stall request. Pipeline control uses it to hold the consumer for one cycle and push one bubble into Memory. On the following cycle the load has moved to Write Back, and its data is taken from RY.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying producer for a source, that operand's select is 2'b00 and the operand equals the register-file value; a select never takes the value 2'b11.
- R2: When the Memory-stage producer writes a register, is not a load, has a nonzero destination and that destination equals the source, the select is 2'b01 and the operand equals the RZ value.
- R3: When the Write Back-stage producer writes a nonzero destination equal to the source and R2 does not apply, the select is 2'b10 and the operand equals the RY value.
- R4: When both producers qualify for the same source, the Memory-stage (younger) result wins with select 2'b01.
- R5: A producer whose write flag is low is ignored for forwarding and for the stall.
- R6: A producer whose destination is register 0 is ignored for forwarding and for the stall, and register-0 sources always read the register file.
- R7: When the Memory-stage producer is a writing load with a nonzero destination equal to either source, the stall output is 1. The RZ path is not selected for that source, which falls back to RY (select 2'b10) if R3 applies, else to the register file.
- R8: The stall output is 1 only in the R7 case; in particular, a load in Write Back is forwarded from RY with no stall.
- R9: The two operands are selected independently: each may take a different path in the same cycle.
- R10: Selects, operands and stall are combinational: they reflect the inputs in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| ex_src_a | input | REG_AW | Source register number of operand A in Compute |
| ex_src_b | input | REG_AW | Source register number of operand B in Compute |
| mem_dst | input | REG_AW | Destination of the Memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_AW | Destination of the Write Back-stage instruction |
| wb_wr | input | 1 | Write Back-stage instruction writes a register |
| rf_a | input | DATA_W | Register-file value for operand A |
| rf_b | input | DATA_W | Register-file value for operand B |
| rz_val | input | DATA_W | Result held in the Compute/Memory buffer |
| ry_val | input | DATA_W | Value held in the Memory/Write Back buffer |
| op_a | output | DATA_W | Operand A delivered to the ALU |
| op_b | output | DATA_W | Operand B delivered to the ALU |
| sel_a | output | 2 | Operand A path: 00 register file, 01 RZ, 10 RY |
| sel_b | output | 2 | Operand B path: 00 register file, 01 RZ, 10 RY |
| stall | output | 1 | One-cycle load-use hold request |

## Verification
The embedded checks treat every input as a stable level sampled at the rising edge. They assume that a bubble reaches this block as a producer with its write flag low, so an empty stage never forwards. The bench changes inputs only just after a rising edge and compares at the falling edge. It draws register numbers from a four-entry range, so same-source double matches, register-0 producers and load-use collisions occur often, alongside directed cases for each path.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand path encoding shared by the selector, the mux and the top
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_RZ = 2'b01,
    SEL_RY = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS   = 2;
  localparam int unsigned NUM_PROD  = 2;
  localparam int unsigned PROD_MEM  = 0;
  localparam int unsigned PROD_WB   = 1;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              wr,
  output logic              hit
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live;
  logic same_reg;

  always_comb begin
    dst_live = wr && (dst != ZERO_REG);
    same_reg = (dst == src);
    hit      = dst_live && same_reg;
  end

endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_mem,
  input  logic     mem_load,
  input  logic     hit_wb,
  output fwd_sel_e sel,
  output logic     load_use
);

  logic mem_usable;

  always_comb begin
    mem_usable = hit_mem && !mem_load;
    load_use   = hit_mem && mem_load;
    if (mem_usable)  sel = SEL_RZ;
    else if (hit_wb) sel = SEL_RY;
    else             sel = SEL_RF;
  end

  // Younger producer wins whenever its result is already in RZ
  p_younger_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mem && hit_wb && !mem_load) |-> (sel == SEL_RZ));

  // A pending load never drives the RZ path
  p_load_not_from_rz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |-> (sel != SEL_RZ));

  // Legal encodings only
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] rz_val,
  input  logic [DATA_W-1:0] ry_val,
  output logic [DATA_W-1:0] op
);

  always_comb begin
    unique case (sel)
      SEL_RZ:  op = rz_val;
      SEL_RY:  op = ry_val;
      default: op = rf_val;
    endcase
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] rz_val,
  input  logic [DATA_W-1:0] ry_val,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              stall
);

  logic [REG_AW-1:0] src_v   [NUM_OPS];
  logic [DATA_W-1:0] rf_v    [NUM_OPS];
  logic [DATA_W-1:0] op_v    [NUM_OPS];
  fwd_sel_e          sel_v   [NUM_OPS];
  logic [NUM_OPS-1:0] load_use_v;

  logic [REG_AW-1:0] prod_dst [NUM_PROD];
  logic              prod_wr  [NUM_PROD];

  always_comb begin
    src_v[0]           = ex_src_a;
    src_v[1]           = ex_src_b;
    rf_v[0]            = rf_a;
    rf_v[1]            = rf_b;
    prod_dst[PROD_MEM] = mem_dst;
    prod_wr[PROD_MEM]  = mem_wr;
    prod_dst[PROD_WB]  = wb_dst;
    prod_wr[PROD_WB]   = wb_wr;
  end

  for (genvar g_op = 0; g_op < NUM_OPS; g_op++) begin : g_operand
    logic [NUM_PROD-1:0] hit;

    for (genvar g_pr = 0; g_pr < NUM_PROD; g_pr++) begin : g_prod
      fwd_hit #(.REG_AW(REG_AW)) u_hit (
        .src (src_v[g_op]),
        .dst (prod_dst[g_pr]),
        .wr  (prod_wr[g_pr]),
        .hit (hit[g_pr])
      );
    end

    fwd_select u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_mem  (hit[PROD_MEM]),
      .mem_load (mem_load),
      .hit_wb   (hit[PROD_WB]),
      .sel      (sel_v[g_op]),
      .load_use (load_use_v[g_op])
    );

    fwd_opmux #(.DATA_W(DATA_W)) u_mux (
      .sel    (sel_v[g_op]),
      .rf_val (rf_v[g_op]),
      .rz_val (rz_val),
      .ry_val (ry_val),
      .op     (op_v[g_op])
    );
  end

  always_comb begin
    op_a  = op_v[0];
    op_b  = op_v[1];
    sel_a = sel_v[0];
    sel_b = sel_v[1];
    stall = |load_use_v;
  end

  // Delivered operand matches the path announced by the select
  p_rz_value_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SEL_RZ) |-> (op_a == rz_val));
  p_rz_value_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == SEL_RZ) |-> (op_b == rz_val));
  p_ry_value_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SEL_RY) |-> (op_a == ry_val));
  p_ry_value_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == SEL_RY) |-> (op_b == ry_val));

  // No writers in flight: register file only, no stall
  p_idle_rf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr && !wb_wr) |-> (op_a == rf_a && op_b == rf_b && !stall));

  // Register 0 producers never bypass
  p_zero_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dst == '0 && wb_dst == '0) |->
      (sel_a == SEL_RF && sel_b == SEL_RF && !stall));

  // Stall only for a writing load in Memory
  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (mem_wr && mem_load && mem_dst != '0));

  // While stalling, neither operand is drawn from RZ
  p_stall_no_rz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sel_a != SEL_RZ && sel_b != SEL_RZ));

endmodule

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

  localparam int DATA_W = 32;
  localparam int REG_AW = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [REG_AW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
  logic              mem_wr, mem_load, wb_wr;
  logic [DATA_W-1:0] rf_a, rf_b, rz_val, ry_val;
  logic [DATA_W-1:0] op_a, op_b;
  logic [1:0]        sel_a, sel_b;
  logic              stall;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  fwd_unit #(.DATA_W(DATA_W), .REG_AW(REG_AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .rf_a(rf_a), .rf_b(rf_b), .rz_val(rz_val), .ry_val(ry_val),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
  );

  // Behavioural reference: path code per requirement text
  function automatic int ref_path(input int src);
    if (src != 0 && mem_wr && int'(mem_dst) == src && !mem_load) return 1;
    if (src != 0 && wb_wr && int'(wb_dst) == src) return 2;
    return 0;
  endfunction

  function automatic logic [DATA_W-1:0] ref_val(input int path, input logic [DATA_W-1:0] rf);
    if (path == 1) return rz_val;
    if (path == 2) return ry_val;
    return rf;
  endfunction

  function automatic bit ref_stall();
    return mem_wr && mem_load && mem_dst != 0 &&
           (mem_dst == ex_src_a || mem_dst == ex_src_b);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int pa, pb;
    pa = ref_path(int'(ex_src_a));
    pb = ref_path(int'(ex_src_b));
    chk(req, "sel_a", {30'd0, sel_a}, pa[DATA_W-1:0]);
    chk(req, "sel_b", {30'd0, sel_b}, pb[DATA_W-1:0]);
    chk(req, "op_a", op_a, ref_val(pa, rf_a));
    chk(req, "op_b", op_b, ref_val(pb, rf_b));
    chk(req, "stall", {31'd0, stall}, {31'd0, ref_stall()});
  endtask

  task automatic drive(input int sa, input int sb, input int md, input bit mw,
                       input bit ml, input int wd, input bit ww);
    @(posedge clk);
    #1;
    ex_src_a = sa[REG_AW-1:0]; ex_src_b = sb[REG_AW-1:0];
    mem_dst  = md[REG_AW-1:0]; mem_wr = mw; mem_load = ml;
    wb_dst   = wd[REG_AW-1:0]; wb_wr = ww;
    rf_a = $urandom; rf_b = $urandom; rz_val = $urandom; ry_val = $urandom;
    @(negedge clk);
  endtask

  task automatic expect_pin(input string req, input logic [1:0] ea,
                            input logic [1:0] eb, input bit es);
    chk(req, "sel_a directed", {30'd0, sel_a}, {30'd0, ea});
    chk(req, "sel_b directed", {30'd0, sel_b}, {30'd0, eb});
    chk(req, "stall directed", {31'd0, stall}, {31'd0, es});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
    mem_wr = 0; mem_load = 0; wb_wr = 0;
    rf_a = 32'h1111_1111; rf_b = 32'h2222_2222;
    rz_val = 32'h3333_3333; ry_val = 32'h4444_4444;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_pin("R1", 2'b00, 2'b00, 1'b0);   // reset state
    compare("R1");
    @(posedge clk); #1 rst_n = 1'b1;

    drive(3, 4, 7, 1, 0, 8, 1);  compare("R1"); expect_pin("R1", 2'b00, 2'b00, 0);
    drive(5, 4, 5, 1, 0, 8, 1);  compare("R2"); expect_pin("R2", 2'b01, 2'b00, 0);
    drive(3, 9, 7, 1, 0, 9, 1);  compare("R3"); expect_pin("R3", 2'b00, 2'b10, 0);
    drive(6, 6, 6, 1, 0, 6, 1);  compare("R4"); expect_pin("R4", 2'b01, 2'b01, 0);
    drive(6, 2, 6, 0, 0, 2, 0);  compare("R5"); expect_pin("R5", 2'b00, 2'b00, 0);
    drive(6, 1, 6, 0, 1, 1, 1);  compare("R5"); expect_pin("R5", 2'b00, 2'b10, 0);
    drive(0, 0, 0, 1, 0, 0, 1);  compare("R6"); expect_pin("R6", 2'b00, 2'b00, 0);
    drive(0, 3, 0, 1, 1, 3, 1);  compare("R6"); expect_pin("R6", 2'b00, 2'b10, 0);
    drive(7, 2, 7, 1, 1, 8, 1);  compare("R7"); expect_pin("R7", 2'b00, 2'b00, 1);
    drive(4, 7, 7, 1, 1, 7, 1);  compare("R7"); expect_pin("R7", 2'b00, 2'b10, 1);
    drive(7, 3, 0, 0, 0, 7, 1);  compare("R8"); expect_pin("R8", 2'b10, 2'b00, 0);
    drive(1, 2, 9, 1, 1, 10, 1); compare("R8"); expect_pin("R8", 2'b00, 2'b00, 0);
    drive(11, 12, 11, 1, 0, 12, 1); compare("R9"); expect_pin("R9", 2'b01, 2'b10, 0);
    drive(12, 11, 11, 1, 0, 12, 1); compare("R9"); expect_pin("R9", 2'b10, 2'b01, 0);

    // R10: random traffic over a tiny register range, compared every cycle
    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
      compare("R10");
    end

    finish_run();
  end

endmodule